// File: doc/BRIEF.md
# Training ordered set generator

This block produces the transmit stream of training ordered sets for one lane of a serial link that uses 128b/130b-style block coding. Every block is 16 byte symbols, one per clock, with a 2-bit sync header presented alongside the first symbol. The header is flagged by a block-start strobe. Control inputs choose between the two training set kinds (TS1 and TS2). They also supply the link and lane numbers, the fast-training count, the rate and speed-change flags, the training-control bits, and the equalization fields carried in symbols 6 to 9. Inside the generator, those fields are placed at their fixed bit positions and a parity bit is computed over the TS1 equalization request.

The sequencer runs freely once reset is released. On a fixed block count it inserts an idle-exit block, which is a low-frequency 00h/FFh pattern that lets the far receiver detect the end of electrical idle. It has three named states. ST_WAIT is the single cycle after reset. ST_EIE emits an idle-exit block and ST_TS emits a training block. The transitions are ST_WAIT to ST_EIE on the first clock edge after reset. At the end of each block, ST_EIE or ST_TS goes to ST_EIE when the block counter wraps and to ST_TS otherwise. Reset returns to ST_WAIT from any state. The control inputs are latched only on the edge that begins a block, so a block never mixes two settings.

Top module: `train_os_gen`

## Requirements
- R1: After reset release the first block starts on the first rising clock edge. Blocks follow back to back, each being 16 cycles with o_valid high and o_sym_idx counting 0 to 15. o_blk_start is high and o_hdr is 01b on symbol 0 only, and o_hdr is 00b otherwise. During reset o_valid, o_blk_start and o_hdr are all zero.
- R2: The first block after reset is an idle-exit block. It is followed by 31 training blocks, and an idle-exit block then recurs every 32 blocks. o_eie_blk is high for all 16 cycles of an idle-exit block.
- R3: An idle-exit block carries 00h on even symbol indices and FFh on odd ones.
- R4: Symbol 0 is 1Eh when i_ts2 is 0 (TS1) and 2Dh when i_ts2 is 1 (TS2). Symbols 1, 2 and 3 are i_link, i_lane and i_nfts.
- R5: Symbol 4 has the following layout: bit 0 is 0, bits 3:1 are 111b, bit 4 is i_rate16, bit 5 is 0, bit 6 is i_auto_chg and bit 7 is i_speed_chg.
- R6: In symbol 5, bits 7:5 are 0 and bits 3:0 are i_tctl[3:0]. Bit 4 is i_tctl[4] in TS1 and 0 in TS2.
- R7: TS1 symbol 6 carries i_eq_phase in bits 1:0, i_eie_rst in bit 2, i_txp in bits 6:3 and i_use_preset in bit 7.
- R8: In TS1, symbol 7 bits 5:0 carry i_fs when i_eq_phase is 01b and i_pre otherwise. Symbol 8 bits 5:0 carry i_lf when i_eq_phase is 01b and i_cur otherwise. Bits 7:6 of both symbols are 0.
- R9: TS1 symbol 9 carries i_post in bits 5:0, i_reject in bit 6, and a parity bit in bit 7. The parity bit makes the XOR of symbol 6 bits 7:0, symbol 7 bits 5:0, symbol 8 bits 5:0 and symbol 9 bits 5:0 and 7 equal to zero.
- R10: TS2 symbol 6 has bits 4:0 at 0, i_redo_rate in bit 5, i_quiesce in bit 6 and i_redo_req in bit 7. TS2 symbol 7 is {1, i_txp16, i_hint16} with i_hint16 in bits 2:0. TS2 symbols 8 to 15 are 45h.
- R11: TS1 symbols 10 to 15 are 4Ah.
- R12: Inputs are sampled on the rising edge that begins a block, that is, the values in the last cycle of the preceding block. An input change during a block does not alter that block.
- R13: An assertion of reset in the middle of a block stops output at once. After release, the sequence restarts with an idle-exit block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| i_ts2 | input | 1 | 0 selects TS1, 1 selects TS2 |
| i_link | input | 8 | Link number |
| i_lane | input | 8 | Lane number |
| i_nfts | input | 8 | Fast-training sequence count |
| i_rate16 | input | 1 | Highest-rate support flag |
| i_auto_chg | input | 1 | Autonomous change flag |
| i_speed_chg | input | 1 | Speed-change request |
| i_tctl | input | 5 | Training-control bits |
| i_eq_phase | input | 2 | Equalization phase code (TS1) |
| i_eie_rst | input | 1 | Reset idle-exit interval count (TS1) |
| i_txp | input | 4 | Transmitter preset (TS1) |
| i_use_preset | input | 1 | Request is a preset, not coefficients (TS1) |
| i_pre | input | 6 | Pre-cursor coefficient |
| i_cur | input | 6 | Cursor coefficient |
| i_post | input | 6 | Post-cursor coefficient |
| i_fs | input | 6 | Full-swing value |
| i_lf | input | 6 | Low-frequency value |
| i_reject | input | 1 | Reject coefficient flag |
| i_redo_rate | input | 1 | Redo-equalization rate (TS2) |
| i_quiesce | input | 1 | Quiesce guarantee (TS2) |
| i_redo_req | input | 1 | Redo-equalization request (TS2) |
| i_txp16 | input | 4 | Highest-rate transmitter preset (TS2) |
| i_hint16 | input | 3 | Highest-rate receiver preset hint (TS2) |
| o_valid | output | 1 | Symbol output valid |
| o_blk_start | output | 1 | First symbol of a block |
| o_hdr | output | 2 | Sync header, 01b on block start |
| o_sym | output | 8 | Symbol byte |
| o_sym_idx | output | 4 | Symbol index within block |
| o_eie_blk | output | 1 | Current block is idle-exit |

## Verification
A fixed list of field settings is applied in turn. It covers TS1 in each of the four phase codes, which tells the FS/LF selection apart from the coefficient selection and exercises parity of both values. It also covers TS2 with all fields set and with the masked training bit set, which shows that the TS1 fields do not leak into TS2. Each setting is applied at the start of a block, so the block in flight must still show the old setting while the next one shows the new. This separates sampling at block start from sampling mid-block. The run is long enough to see the second idle-exit block at block 32, and a reset in the middle of a block must restart with an idle-exit block.

// File: rtl/train_os_pkg.sv
package train_os_pkg;

    typedef enum logic [1:0] {
        ST_WAIT = 2'd0,
        ST_EIE  = 2'd1,
        ST_TS   = 2'd2
    } tog_state_e;

    localparam logic [7:0] TS1_ID   = 8'h1E;
    localparam logic [7:0] TS2_ID   = 8'h2D;
    localparam logic [7:0] TS1_FILL = 8'h4A;
    localparam logic [7:0] TS2_FILL = 8'h45;
    localparam logic [1:0] HDR_OS   = 2'b01;
    localparam logic [1:0] PH_ADV   = 2'b01;

    typedef struct packed {
        logic       ts2;
        logic [7:0] link;
        logic [7:0] lane;
        logic [7:0] nfts;
        logic       rate16;
        logic       auto_chg;
        logic       speed_chg;
        logic [4:0] tctl;
        logic [1:0] eq_phase;
        logic       eie_rst;
        logic [3:0] txp;
        logic       use_preset;
        logic [5:0] pre;
        logic [5:0] cur;
        logic [5:0] post;
        logic [5:0] fs;
        logic [5:0] lf;
        logic       reject;
        logic       redo_rate;
        logic       quiesce;
        logic       redo_req;
        logic [3:0] txp16;
        logic [2:0] hint16;
    } tog_fields_t;

endpackage

// File: rtl/tog_capture.sv
module tog_capture
    import train_os_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        i_load,
    input  tog_fields_t i_fields,
    output tog_fields_t o_fields
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            o_fields <= '0;
        end else if (i_load) begin
            o_fields <= i_fields;
        end
    end

endmodule

// File: rtl/tog_seq.sv
module tog_seq
    import train_os_pkg::*;
#(
    parameter int BLK_SYMS   = 16,
    parameter int EIE_PERIOD = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    output logic                        o_load,
    output logic                        o_valid,
    output logic                        o_start,
    output logic                        o_eie,
    output logic [$clog2(BLK_SYMS)-1:0] o_idx
);

    localparam int IDX_W = $clog2(BLK_SYMS);
    localparam int CNT_W = $clog2(EIE_PERIOD);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(BLK_SYMS - 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(EIE_PERIOD - 1);

    tog_state_e       state, state_n;
    logic [IDX_W-1:0] idx, idx_n;
    logic [CNT_W-1:0] blk_cnt, blk_cnt_n;
    logic             load_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_WAIT;
            idx     <= '0;
            blk_cnt <= '0;
        end else begin
            state   <= state_n;
            idx     <= idx_n;
            blk_cnt <= blk_cnt_n;
        end
    end

    always_comb begin
        state_n   = state;
        idx_n     = idx;
        blk_cnt_n = blk_cnt;
        load_n    = 1'b0;
        unique case (state)
            ST_WAIT: begin
                state_n   = ST_EIE;
                idx_n     = '0;
                blk_cnt_n = '0;
                load_n    = 1'b1;
            end
            ST_EIE, ST_TS: begin
                if (idx == IDX_LAST) begin
                    load_n    = 1'b1;
                    idx_n     = '0;
                    blk_cnt_n = (blk_cnt == CNT_LAST) ? '0 : blk_cnt + 1'b1;
                    state_n   = (blk_cnt_n == '0) ? ST_EIE : ST_TS;
                end else begin
                    idx_n = idx + 1'b1;
                end
            end
            default: begin
                state_n = ST_WAIT;
            end
        endcase
    end

    always_comb begin
        o_load  = load_n;
        o_valid = (state != ST_WAIT);
        o_start = (state != ST_WAIT) && (idx == '0);
        o_eie   = (state == ST_EIE);
        o_idx   = idx;
    end

    // Independent block-gap monitor for the idle-exit spacing
    logic [CNT_W:0] mon_gap;
    logic           mon_seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mon_gap  <= '0;
            mon_seen <= 1'b0;
        end else if (o_start) begin
            if (o_eie) begin
                mon_gap  <= '0;
                mon_seen <= 1'b1;
            end else begin
                mon_gap <= mon_gap + 1'b1;
            end
        end
    end

    p_idx_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (o_valid && o_idx != IDX_LAST) |=> (o_idx == IDX_W'($past(o_idx) + 1'b1)));

    p_eie_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (o_start && o_eie && mon_seen) |-> (mon_gap == (CNT_W+1)'(EIE_PERIOD - 1)));

    p_ts_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (o_start && !o_eie) |-> (mon_seen && mon_gap < (CNT_W+1)'(EIE_PERIOD - 1)));

endmodule

// File: rtl/tog_symbuild.sv
module tog_symbuild
    import train_os_pkg::*;
#(
    parameter int BLK_SYMS = 16
) (
    input  tog_fields_t                 i_f,
    input  logic [$clog2(BLK_SYMS)-1:0] i_idx,
    input  logic                        i_eie,
    output logic [7:0]                  o_sym
);

    logic [7:0] s4, s5, s6, s7, s8, s9, fill, id;
    logic       adv, par;

    always_comb begin
        adv  = (i_f.eq_phase == PH_ADV);
        id   = i_f.ts2 ? TS2_ID : TS1_ID;
        fill = i_f.ts2 ? TS2_FILL : TS1_FILL;
        s4   = {i_f.speed_chg, i_f.auto_chg, 1'b0, i_f.rate16, 3'b111, 1'b0};
        s5   = {3'b000, i_f.tctl[4] & ~i_f.ts2, i_f.tctl[3:0]};
        s6   = i_f.ts2 ? {i_f.redo_req, i_f.quiesce, i_f.redo_rate, 5'b00000}
                       : {i_f.use_preset, i_f.txp, i_f.eie_rst, i_f.eq_phase};
        s7   = i_f.ts2 ? {1'b1, i_f.txp16, i_f.hint16}
                       : {2'b00, adv ? i_f.fs : i_f.pre};
        s8   = i_f.ts2 ? TS2_FILL : {2'b00, adv ? i_f.lf : i_f.cur};
        par  = ^{s6, s7[5:0], s8[5:0], i_f.post};
        s9   = i_f.ts2 ? TS2_FILL : {par, i_f.reject, i_f.post};

        if (i_eie) begin
            o_sym = i_idx[0] ? 8'hFF : 8'h00;
        end else begin
            unique case (int'(i_idx))
                0:       o_sym = id;
                1:       o_sym = i_f.link;
                2:       o_sym = i_f.lane;
                3:       o_sym = i_f.nfts;
                4:       o_sym = s4;
                5:       o_sym = s5;
                6:       o_sym = s6;
                7:       o_sym = s7;
                8:       o_sym = s8;
                9:       o_sym = s9;
                default: o_sym = fill;
            endcase
        end
    end

endmodule

// File: rtl/train_os_gen.sv
module train_os_gen
    import train_os_pkg::*;
#(
    parameter int BLK_SYMS   = 16,
    parameter int EIE_PERIOD = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        i_ts2,
    input  logic [7:0]                  i_link,
    input  logic [7:0]                  i_lane,
    input  logic [7:0]                  i_nfts,
    input  logic                        i_rate16,
    input  logic                        i_auto_chg,
    input  logic                        i_speed_chg,
    input  logic [4:0]                  i_tctl,
    input  logic [1:0]                  i_eq_phase,
    input  logic                        i_eie_rst,
    input  logic [3:0]                  i_txp,
    input  logic                        i_use_preset,
    input  logic [5:0]                  i_pre,
    input  logic [5:0]                  i_cur,
    input  logic [5:0]                  i_post,
    input  logic [5:0]                  i_fs,
    input  logic [5:0]                  i_lf,
    input  logic                        i_reject,
    input  logic                        i_redo_rate,
    input  logic                        i_quiesce,
    input  logic                        i_redo_req,
    input  logic [3:0]                  i_txp16,
    input  logic [2:0]                  i_hint16,
    output logic                        o_valid,
    output logic                        o_blk_start,
    output logic [1:0]                  o_hdr,
    output logic [7:0]                  o_sym,
    output logic [$clog2(BLK_SYMS)-1:0] o_sym_idx,
    output logic                        o_eie_blk
);

    localparam int IDX_W = $clog2(BLK_SYMS);

    tog_fields_t      in_f, cur_f;
    logic             load;
    logic [IDX_W-1:0] idx;

    always_comb begin
        in_f.ts2        = i_ts2;
        in_f.link       = i_link;
        in_f.lane       = i_lane;
        in_f.nfts       = i_nfts;
        in_f.rate16     = i_rate16;
        in_f.auto_chg   = i_auto_chg;
        in_f.speed_chg  = i_speed_chg;
        in_f.tctl       = i_tctl;
        in_f.eq_phase   = i_eq_phase;
        in_f.eie_rst    = i_eie_rst;
        in_f.txp        = i_txp;
        in_f.use_preset = i_use_preset;
        in_f.pre        = i_pre;
        in_f.cur        = i_cur;
        in_f.post       = i_post;
        in_f.fs         = i_fs;
        in_f.lf         = i_lf;
        in_f.reject     = i_reject;
        in_f.redo_rate  = i_redo_rate;
        in_f.quiesce    = i_quiesce;
        in_f.redo_req   = i_redo_req;
        in_f.txp16      = i_txp16;
        in_f.hint16     = i_hint16;
    end

    tog_seq #(
        .BLK_SYMS   (BLK_SYMS),
        .EIE_PERIOD (EIE_PERIOD)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .o_load  (load),
        .o_valid (o_valid),
        .o_start (o_blk_start),
        .o_eie   (o_eie_blk),
        .o_idx   (idx)
    );

    tog_capture u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .i_load   (load),
        .i_fields (in_f),
        .o_fields (cur_f)
    );

    tog_symbuild #(
        .BLK_SYMS (BLK_SYMS)
    ) u_build (
        .i_f   (cur_f),
        .i_idx (idx),
        .i_eie (o_eie_blk),
        .o_sym (o_sym)
    );

    assign o_sym_idx = idx;
    assign o_hdr     = o_blk_start ? HDR_OS : 2'b00;

    // Stream monitor: rebuilds the TS1 parity from the emitted bytes
    logic [7:0] mon_s6;
    logic [5:0] mon_s7, mon_s8;
    logic       mon_ts2;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mon_s6  <= '0;
            mon_s7  <= '0;
            mon_s8  <= '0;
            mon_ts2 <= 1'b0;
        end else if (o_valid && !o_eie_blk) begin
            if (int'(idx) == 0) mon_ts2 <= (o_sym == TS2_ID);
            if (int'(idx) == 6) mon_s6  <= o_sym;
            if (int'(idx) == 7) mon_s7  <= o_sym[5:0];
            if (int'(idx) == 8) mon_s8  <= o_sym[5:0];
        end
    end

    p_hdr_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
        o_blk_start |-> (o_hdr == HDR_OS && o_valid));

    p_eie_bytes_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (o_valid && o_eie_blk) |-> (o_sym == 8'h00 || o_sym == 8'hFF));

    p_eie_toggle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (o_valid && o_eie_blk && !o_blk_start) |-> (o_sym == ~$past(o_sym)));

    p_ts_id_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (o_blk_start && !o_eie_blk) |-> (o_sym == TS1_ID || o_sym == TS2_ID));

    p_rate_bits_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (o_valid && !o_eie_blk && int'(idx) == 4) |-> (o_sym[3:0] == 4'b1110));

    p_parity_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (o_valid && !o_eie_blk && int'(idx) == 9 && !mon_ts2)
        |-> ((^{mon_s6, mon_s7, mon_s8, o_sym[7], o_sym[5:0]}) == 1'b0));

endmodule

// File: tb/train_os_gen_bench.sv
`timescale 1ns/1ps
module train_os_gen_bench;

    typedef struct packed {
        logic       ts2;
        logic [7:0] link;
        logic [7:0] lane;
        logic [7:0] nfts;
        logic       rate16;
        logic       auto_chg;
        logic       spd;
        logic [4:0] tctl;
        logic [1:0] phase;
        logic       eie_rst;
        logic [3:0] txp;
        logic       use_p;
        logic [5:0] pre;
        logic [5:0] cur;
        logic [5:0] post;
        logic [5:0] fs;
        logic [5:0] lf;
        logic       reject;
        logic       redo_rate;
        logic       quiesce;
        logic       redo_req;
        logic [3:0] txp16;
        logic [2:0] hint16;
    } cfg_t;

    localparam int NVEC = 6;
    localparam cfg_t VEC [NVEC] = '{
        '{ts2:1'b0, link:8'h03, lane:8'h01, nfts:8'h20, rate16:1'b1, auto_chg:1'b0, spd:1'b1,
          tctl:5'h10, phase:2'b01, eie_rst:1'b0, txp:4'h7, use_p:1'b1, pre:6'h05, cur:6'h22,
          post:6'h0B, fs:6'h3F, lf:6'h15, reject:1'b0, redo_rate:1'b1, quiesce:1'b1,
          redo_req:1'b1, txp16:4'h9, hint16:3'h5},
        '{ts2:1'b0, link:8'hA5, lane:8'h0F, nfts:8'hFF, rate16:1'b0, auto_chg:1'b1, spd:1'b0,
          tctl:5'h05, phase:2'b10, eie_rst:1'b1, txp:4'h2, use_p:1'b0, pre:6'h05, cur:6'h22,
          post:6'h0B, fs:6'h3F, lf:6'h15, reject:1'b1, redo_rate:1'b0, quiesce:1'b0,
          redo_req:1'b0, txp16:4'h0, hint16:3'h0},
        '{ts2:1'b0, link:8'hFF, lane:8'hFF, nfts:8'h00, rate16:1'b1, auto_chg:1'b1, spd:1'b1,
          tctl:5'h1F, phase:2'b00, eie_rst:1'b1, txp:4'hF, use_p:1'b1, pre:6'h3F, cur:6'h3F,
          post:6'h3F, fs:6'h00, lf:6'h00, reject:1'b1, redo_rate:1'b1, quiesce:1'b1,
          redo_req:1'b1, txp16:4'hF, hint16:3'h7},
        '{ts2:1'b1, link:8'h12, lane:8'h34, nfts:8'h56, rate16:1'b1, auto_chg:1'b0, spd:1'b1,
          tctl:5'h1A, phase:2'b11, eie_rst:1'b1, txp:4'hA, use_p:1'b1, pre:6'h11, cur:6'h2A,
          post:6'h19, fs:6'h30, lf:6'h0C, reject:1'b1, redo_rate:1'b1, quiesce:1'b0,
          redo_req:1'b1, txp16:4'h6, hint16:3'h2},
        '{ts2:1'b0, link:8'h00, lane:8'h00, nfts:8'h00, rate16:1'b0, auto_chg:1'b0, spd:1'b0,
          tctl:5'h00, phase:2'b11, eie_rst:1'b0, txp:4'h0, use_p:1'b0, pre:6'h01, cur:6'h00,
          post:6'h00, fs:6'h2A, lf:6'h15, reject:1'b0, redo_rate:1'b1, quiesce:1'b1,
          redo_req:1'b1, txp16:4'hF, hint16:3'h7},
        '{ts2:1'b1, link:8'hFF, lane:8'hFF, nfts:8'hFF, rate16:1'b1, auto_chg:1'b1, spd:1'b1,
          tctl:5'h1F, phase:2'b01, eie_rst:1'b1, txp:4'hF, use_p:1'b1, pre:6'h3F, cur:6'h3F,
          post:6'h3F, fs:6'h3F, lf:6'h3F, reject:1'b1, redo_rate:1'b1, quiesce:1'b1,
          redo_req:1'b1, txp16:4'hF, hint16:3'h7}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       i_ts2, i_rate16, i_auto_chg, i_speed_chg, i_eie_rst, i_use_preset;
    logic       i_reject, i_redo_rate, i_quiesce, i_redo_req;
    logic [7:0] i_link, i_lane, i_nfts;
    logic [4:0] i_tctl;
    logic [1:0] i_eq_phase;
    logic [3:0] i_txp, i_txp16;
    logic [5:0] i_pre, i_cur, i_post, i_fs, i_lf;
    logic [2:0] i_hint16;
    logic       o_valid, o_blk_start, o_eie_blk;
    logic [1:0] o_hdr;
    logic [7:0] o_sym;
    logic [3:0] o_sym_idx;

    int checks = 0;
    int errors = 0;
    int blk_no = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    train_os_gen u_train_os_gen (
        .clk(clk), .rst_n(rst_n), .i_ts2(i_ts2), .i_link(i_link), .i_lane(i_lane),
        .i_nfts(i_nfts), .i_rate16(i_rate16), .i_auto_chg(i_auto_chg),
        .i_speed_chg(i_speed_chg), .i_tctl(i_tctl), .i_eq_phase(i_eq_phase),
        .i_eie_rst(i_eie_rst), .i_txp(i_txp), .i_use_preset(i_use_preset),
        .i_pre(i_pre), .i_cur(i_cur), .i_post(i_post), .i_fs(i_fs), .i_lf(i_lf),
        .i_reject(i_reject), .i_redo_rate(i_redo_rate), .i_quiesce(i_quiesce),
        .i_redo_req(i_redo_req), .i_txp16(i_txp16), .i_hint16(i_hint16),
        .o_valid(o_valid), .o_blk_start(o_blk_start), .o_hdr(o_hdr), .o_sym(o_sym),
        .o_sym_idx(o_sym_idx), .o_eie_blk(o_eie_blk)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic apply(input cfg_t c);
        i_ts2 = c.ts2; i_link = c.link; i_lane = c.lane; i_nfts = c.nfts;
        i_rate16 = c.rate16; i_auto_chg = c.auto_chg; i_speed_chg = c.spd;
        i_tctl = c.tctl; i_eq_phase = c.phase; i_eie_rst = c.eie_rst; i_txp = c.txp;
        i_use_preset = c.use_p; i_pre = c.pre; i_cur = c.cur; i_post = c.post;
        i_fs = c.fs; i_lf = c.lf; i_reject = c.reject; i_redo_rate = c.redo_rate;
        i_quiesce = c.quiesce; i_redo_req = c.redo_req; i_txp16 = c.txp16;
        i_hint16 = c.hint16;
    endtask

    function automatic logic [7:0] exp_sym(input cfg_t c, input int k);
        logic [7:0] s6, s7, s8;
        logic       p;
        s6 = c.ts2 ? {c.redo_req, c.quiesce, c.redo_rate, 5'b0}
                   : {c.use_p, c.txp, c.eie_rst, c.phase};
        s7 = c.ts2 ? {1'b1, c.txp16, c.hint16}
                   : {2'b0, (c.phase == 2'b01) ? c.fs : c.pre};
        s8 = {2'b0, (c.phase == 2'b01) ? c.lf : c.cur};
        p  = ^{s6, s7[5:0], s8[5:0], c.post};
        case (k)
            0: return c.ts2 ? 8'h2D : 8'h1E;
            1: return c.link;
            2: return c.lane;
            3: return c.nfts;
            4: return {c.spd, c.auto_chg, 1'b0, c.rate16, 3'b111, 1'b0};
            5: return {3'b0, c.ts2 ? 1'b0 : c.tctl[4], c.tctl[3:0]};
            6: return s6;
            7: return s7;
            8: return c.ts2 ? 8'h45 : s8;
            9: return c.ts2 ? 8'h45 : {p, c.reject, c.post};
            default: return c.ts2 ? 8'h45 : 8'h4A;
        endcase
    endfunction

    function automatic string req_of(input logic ts2, input int k);
        if (k <= 3) return "R4";
        if (k == 4) return "R5";
        if (k == 5) return "R6";
        if (ts2) return "R10";
        if (k == 6) return "R7";
        if (k <= 8) return "R8";
        if (k == 9) return "R9";
        return "R11";
    endfunction

    // Reads one block starting at a negedge where o_blk_start is high
    task automatic get_block(output logic [7:0] s [16], output logic eie);
        eie = o_eie_blk;
        chk(o_blk_start === 1'b1, "R1 block start", 32'(o_blk_start), 32'd1);
        chk(o_eie_blk === ((blk_no % 32) == 0), "R2 idle-exit position",
            32'(o_eie_blk), 32'((blk_no % 32) == 0));
        for (int k = 0; k < 16; k++) begin
            chk(o_valid === 1'b1 && o_sym_idx === 4'(k) &&
                o_hdr === ((k == 0) ? 2'b01 : 2'b00) &&
                o_blk_start === (k == 0) && o_eie_blk === eie,
                "R1 framing", {o_valid, o_blk_start, o_hdr, o_sym_idx},
                {1'b1, 1'(k == 0), (k == 0) ? 2'b01 : 2'b00, 4'(k)});
            s[k] = o_sym;
            @(negedge clk);
        end
        blk_no++;
    endtask

    task automatic verify(input logic [7:0] s [16], input logic eie, input cfg_t c,
                          input string note);
        if (eie) begin
            for (int k = 0; k < 16; k++)
                chk(s[k] === ((k % 2) ? 8'hFF : 8'h00), "R3 idle-exit pattern",
                    32'(s[k]), (k % 2) ? 32'hFF : 32'h00);
        end else begin
            for (int k = 0; k < 16; k++)
                chk(s[k] === exp_sym(c, k), {req_of(c.ts2, k), note},
                    32'(s[k]), 32'(exp_sym(c, k)));
        end
    endtask

    initial begin
        logic [7:0] s [16];
        logic       eie;
        cfg_t       prev;

        prev = VEC[0];
        apply(prev);
        repeat (3) @(negedge clk);
        chk(o_valid === 1'b0 && o_blk_start === 1'b0 && o_hdr === 2'b00,
            "R1 reset state", {o_valid, o_blk_start, o_hdr}, 32'd0);
        rst_n = 1'b1;
        chk(o_valid === 1'b0, "R1 idle before first edge", 32'(o_valid), 32'd0);
        @(negedge clk);
        blk_no = 0;
        get_block(s, eie);
        chk(eie === 1'b1, "R2 first block is idle-exit", 32'(eie), 32'd1);
        verify(s, eie, prev, "");

        // Vector walk: new setting at block start, old setting must hold (R12)
        for (int i = 1; i < NVEC; i++) begin
            apply(VEC[i]);
            get_block(s, eie);
            verify(s, eie, prev, " R12 hold");
            prev = VEC[i];
        end
        while (blk_no <= 32) begin
            get_block(s, eie);
            verify(s, eie, prev, "");
        end

        // Input change in the middle of a block (R12)
        apply(VEC[2]);
        get_block(s, eie);
        verify(s, eie, prev, "");
        repeat (7) @(negedge clk);
        apply(VEC[3]);
        repeat (9) @(negedge clk);
        blk_no++;
        get_block(s, eie);
        verify(s, eie, VEC[3], " R12 mid-block change");
        prev = VEC[3];

        // Reset in the middle of a block (R13)
        repeat (5) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(o_valid === 1'b0 && o_blk_start === 1'b0, "R13 reset mid-block",
            {o_valid, o_blk_start}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        blk_no = 0;
        get_block(s, eie);
        chk(eie === 1'b1, "R13 restart with idle-exit", 32'(eie), 32'd1);
        verify(s, eie, prev, "");
        get_block(s, eie);
        verify(s, eie, prev, " R13 after restart");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule